// File: doc/BRIEF.md
# Register Region Access Decoder

This block sits between a memory-mapped bus slave port and a group of register handlers. A request arrives with an address, a write flag, a size code and 64-bit write data. The block subtracts a configured base address and looks the offset up in a table of regions held as parameters. Each region has a start offset, a length, a handler select, a mask of permitted access widths and a behaviour kind. The block then checks the access size and the address alignment against the region that matched.

An accepted access reaches the selected handler in the same cycle. The handler sees a one-cycle enable, the offset inside its region and right-justified write data. Read data comes back on the following cycle, placed on its little-endian byte lanes. Regions can also read as zero, read as all ones, or ignore writes without involving any handler. An access that matches no region, or that fails the width or alignment check, never raises an error. A read of that kind returns zero and a write of that kind is dropped.

The default table has five regions:

| Start | Length | Select | Widths | Kind |
|-------|--------|--------|--------|------|
| 0x000 | 0x80 | 1 | 8, 32 | handler |
| 0x080 | 0x10 | 2 | 32, 64 | handler |
| 0x100 | 0x20 | – | 8, 32, 64 | read-as-zero |
| 0x200 | 0x20 | – | 32 | read-as-ones |
| 0x300 | 0x40 | 3 | 32, 64 | handler read, write ignored |

The base address is 0x1000. Offsets 0x090 to 0x0FF fall in a gap that no region covers.

Top module: `reg_region_decoder`

## Requirements
- R1: The offset is the bus address minus the base address, with no wrap-around. An address below the base matches no region.
- R2: A region matches when start <= offset < start + length. If several regions match, the one with the lowest index wins. The handler receives that region's select on `hnd_sel` and the value offset minus start on `hnd_offset`.
- R3: Size code 00 (8-bit) is accepted only if bit 0 of the region's width mask is set. Any alignment is allowed for it.
- R4: Size code 10 (32-bit) is accepted only if bit 1 of the width mask is set and address bits [1:0] are zero.
- R5: Size code 11 (64-bit) is accepted only if bit 2 of the width mask is set and address bits [2:0] are zero. Size code 01 is always rejected.
- R6: A read that matches no region or is rejected returns zero with `rsp_valid` high.
- R7: A write that matches no region or is rejected raises no handler enable.
- R8: Kind 1 reads as zero and kind 2 reads as ones on the accessed byte lanes, with zero on the other lanes. Both kinds ignore writes, and neither raises a handler enable.
- R9: Kind 3 forwards reads to its handler and ignores writes. Kind 0 forwards both reads and writes.
- R10: Byte lanes are little-endian. The access uses lanes starting at address bits [2:0]. Write data from those lanes reaches `hnd_wdata` right-justified with the upper bits zero. Handler read data is masked to the access size and shifted back onto the same lanes.
- R11: `hnd_en` is high in the request cycle, and only for a forwarded access. `rsp_valid` is high exactly one cycle after each read request. A write never produces `rsp_valid`.
- R12: While reset is active, `rsp_valid` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 = 8-bit, 01 = 16-bit (never accepted), 10 = 32-bit, 11 = 64-bit |
| req_addr | input | AW | Byte address on the bus |
| req_wdata | input | 64 | Write data on little-endian lanes |
| rsp_valid | output | 1 | Read response strobe, one cycle after the read |
| rsp_rdata | output | 64 | Read data on little-endian lanes |
| hnd_en | output | 1 | Handler access enable |
| hnd_write | output | 1 | Handler access direction |
| hnd_sel | output | SELW | Selected handler |
| hnd_offset | output | AW | Offset inside the matched region |
| hnd_size | output | 2 | Size code of the forwarded access |
| hnd_wdata | output | 64 | Right-justified write data |
| hnd_rdata | input | 64 | Right-justified handler read data, valid while hnd_en is high |

## Verification
The response register for one read can update in the same cycle that the next request drives a handler enable. That next request may be a write to the same handler bytes. The bench provokes this with back-to-back sequences: a read, then a write to the same location, then a read again. The reference model is compared on every clock. The first response must show the old bytes, the write enable must appear with correct lanes, and the second response must show the new bytes. A long pseudo-random run also mixes unmatched, misaligned and forbidden-width accesses into the same stream.

// File: rtl/reg_region_decoder.sv
`timescale 1ns/1ps
module reg_region_decoder #(
  parameter int AW   = 16,
  parameter int NREG = 5,
  parameter int SELW = 2,
  parameter logic [AW-1:0]        BASE      = 16'h1000,
  parameter logic [NREG*AW-1:0]   RG_START  = {16'h0300, 16'h0200, 16'h0100, 16'h0080, 16'h0000},
  parameter logic [NREG*AW-1:0]   RG_LEN    = {16'h0040, 16'h0020, 16'h0020, 16'h0010, 16'h0080},
  parameter logic [NREG*SELW-1:0] RG_SEL    = {2'd3, 2'd0, 2'd0, 2'd2, 2'd1},
  parameter logic [NREG*3-1:0]    RG_WIDTHS = {3'b110, 3'b010, 3'b111, 3'b110, 3'b011},
  parameter logic [NREG*2-1:0]    RG_KIND   = {2'd3, 2'd2, 2'd1, 2'd0, 2'd0}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [63:0]     req_wdata,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            hnd_en,
  output logic            hnd_write,
  output logic [SELW-1:0] hnd_sel,
  output logic [AW-1:0]   hnd_offset,
  output logic [1:0]      hnd_size,
  output logic [63:0]     hnd_wdata,
  input  logic [63:0]     hnd_rdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [1:0] K_HND = 2'd0, K_RAZ = 2'd1, K_RAO = 2'd2, K_RDO = 2'd3;

  logic [AW:0]     diff;
  logic [AW-1:0]   off;
  logic            below;
  logic [AW-1:0]   st [NREG];
  logic [AW-1:0]   ln [NREG];
  logic [SELW-1:0] sl [NREG];
  logic [2:0]      wm [NREG];
  logic [1:0]      kd [NREG];
  logic [NREG-1:0] hitv;
  logic [IW-1:0]   idx;
  logic            hit, width_ok, accept;
  logic [63:0]     size_mask, rd_val, rd_lane;
  logic [5:0]      shift;

  assign diff  = {1'b0, req_addr} - {1'b0, BASE};
  assign off   = diff[AW-1:0];
  assign below = diff[AW];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign st[g] = RG_START[g*AW +: AW];
    assign ln[g] = RG_LEN[g*AW +: AW];
    assign sl[g] = RG_SEL[g*SELW +: SELW];
    assign wm[g] = RG_WIDTHS[g*3 +: 3];
    assign kd[g] = RG_KIND[g*2 +: 2];
    assign hitv[g] = ({1'b0, off} >= {1'b0, st[g]}) &&
                     ({1'b0, off} <  ({1'b0, st[g]} + {1'b0, ln[g]}));
  end

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hitv[i]) idx = IW'(i);
  end
  assign hit = (|hitv) && !below;

  always_comb begin
    width_ok  = 1'b0;
    size_mask = '0;
    shift     = '0;
    case (req_size)
      2'b00: begin
        width_ok  = wm[idx][0];
        size_mask = 64'h0000_0000_0000_00FF;
        shift     = {req_addr[2:0], 3'b000};
      end
      2'b10: begin
        width_ok  = wm[idx][1] && (req_addr[1:0] == 2'b00);
        size_mask = 64'h0000_0000_FFFF_FFFF;
        shift     = {req_addr[2], 5'b00000};
      end
      2'b11: begin
        width_ok  = wm[idx][2] && (req_addr[2:0] == 3'b000);
        size_mask = '1;
      end
      default: width_ok = 1'b0;
    endcase
  end

  assign accept = req_valid && hit && width_ok;

  assign hnd_en     = accept && (req_write ? (kd[idx] == K_HND)
                                           : (kd[idx] == K_HND || kd[idx] == K_RDO));
  assign hnd_write  = req_write;
  assign hnd_sel    = sl[idx];
  assign hnd_offset = off - st[idx];
  assign hnd_size   = req_size;
  assign hnd_wdata  = (req_wdata >> shift) & size_mask;

  always_comb begin
    case (kd[idx])
      K_RAZ:   rd_val = '0;
      K_RAO:   rd_val = size_mask;
      default: rd_val = hnd_rdata & size_mask;
    endcase
  end
  assign rd_lane = accept ? (rd_val << shift) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_lane : '0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);                                   // R11
  AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);                                   // R11
  AST_EN_ALIGN32: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_en && req_size == 2'b10) |-> (req_addr[1:0] == 2'b00));                // R4
  AST_EN_ALIGN64: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_en && req_size == 2'b11) |-> (req_addr[2:0] == 3'b000));               // R5
  AST_NO_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_en |-> (req_size != 2'b01));                                            // R5
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !accept) |=> (rsp_rdata == 64'd0));             // R6
  AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < BASE) |-> !hnd_en);                                // R1
  AST_RAO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && kd[idx] == K_RAO) |=> (rsp_rdata != 64'd0));       // R8
endmodule

// File: tb/tb_reg_region_decoder.sv
`timescale 1ns/1ps
module tb_reg_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, hnd_en, hnd_write;
  logic [63:0] rsp_rdata, hnd_wdata, hnd_rdata;
  logic [1:0]  hnd_sel, hnd_size;
  logic [15:0] hnd_offset;

  reg_region_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hnd_en(hnd_en),
    .hnd_write(hnd_write), .hnd_sel(hnd_sel), .hnd_offset(hnd_offset),
    .hnd_size(hnd_size), .hnd_wdata(hnd_wdata), .hnd_rdata(hnd_rdata));

  always #10 clk = ~clk;

  int rs [5], rl [5], rsel [5], rk [5];
  logic [2:0] rw [5];
  logic [7:0] hmem [4][256];
  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  bit exp_rv = 1'b0;
  logic [63:0] exp_rd = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always_comb begin
    for (int j = 0; j < 8; j++)
      hnd_rdata[j*8 +: 8] = hmem[hnd_sel][(int'(hnd_offset) + j) & 255];
  end

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit w, logic [1:0] sz, logic [15:0] a, logic [63:0] d, string tag);
    int off, ri, n, hoff, lane;
    bit ok, en;
    logic [63:0] erd, ewd;
    @(negedge clk);
    chk(rsp_valid === exp_rv, "R11", "rsp_valid", 64'(rsp_valid), 64'(exp_rv));
    chk(rsp_rdata === exp_rd, tag, "rsp_rdata", rsp_rdata, exp_rd);
    req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    #2;
    ri = -1;
    off = int'(a) - 32'h1000;
    if (v && off >= 0)
      for (int i = 0; i < 5; i++)
        if (ri < 0 && off >= rs[i] && off < rs[i] + rl[i]) ri = i;
    n = (sz == 2'b00) ? 1 : (sz == 2'b10) ? 4 : (sz == 2'b11) ? 8 : 0;
    lane = int'(a[2:0]);
    ok = (ri >= 0) && ((sz == 2'b00 && rw[ri][0]) ||
                       (sz == 2'b10 && rw[ri][1] && a[1:0] == 2'b00) ||
                       (sz == 2'b11 && rw[ri][2] && a[2:0] == 3'b000));
    en = ok && (w ? (rk[ri] == 0) : (rk[ri] == 0 || rk[ri] == 3));
    hoff = ok ? off - rs[ri] : 0;
    chk(hnd_en === en, tag, "hnd_en", 64'(hnd_en), 64'(en));
    if (en) begin
      chk(hnd_sel === 2'(rsel[ri]), "R2", "hnd_sel", 64'(hnd_sel), 64'(rsel[ri]));
      chk(hnd_offset === 16'(hoff), "R2", "hnd_offset", 64'(hnd_offset), 64'(hoff));
      chk(hnd_write === w && hnd_size === sz, tag, "hnd_write/size",
          {61'd0, hnd_write, hnd_size}, {61'd0, w, sz});
      if (w) begin
        ewd = '0;
        for (int j = 0; j < n; j++) ewd[j*8 +: 8] = d[(lane + j)*8 +: 8];
        chk(hnd_wdata === ewd, "R10", "hnd_wdata", hnd_wdata, ewd);
      end
    end
    erd = '0;
    if (v && !w && ok)
      for (int j = 0; j < n; j++)
        erd[(lane + j)*8 +: 8] = (rk[ri] == 2) ? 8'hFF :
                                 (rk[ri] == 1) ? 8'h00 : hmem[rsel[ri]][(hoff + j) & 255];
    exp_rv = v && !w;
    exp_rd = erd;
    @(posedge clk);
    #1;
    if (en && w)
      for (int j = 0; j < n; j++) hmem[rsel[ri]][(hoff + j) & 255] = d[(lane + j)*8 +: 8];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    nchk++; nerr++;
    $display("FAIL R11 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rs = '{'h000, 'h080, 'h100, 'h200, 'h300};
    rl = '{'h080, 'h010, 'h020, 'h020, 'h040};
    rsel = '{1, 2, 0, 0, 3};
    rk = '{0, 0, 1, 2, 3};
    rw = '{3'b011, 3'b110, 3'b111, 3'b010, 3'b110};
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 256; b++) hmem[s][b] = 8'((s * 37 + b * 13) ^ 8'h5A);

    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(rsp_rdata === 64'd0, "R12", "reset rsp_rdata", rsp_rdata, 64'd0);
    rst_n = 1'b1;

    cyc(1, 1, 2'b00, 16'h1003, 64'h0000_0000_A500_0000, "R3");
    cyc(1, 1, 2'b00, 16'h1005, 64'h0000_3C00_0000_0000, "R10");
    cyc(1, 0, 2'b00, 16'h1003, 64'd0, "R10");
    cyc(1, 1, 2'b10, 16'h1004, 64'h1122_3344_5566_7788, "R4");
    cyc(1, 0, 2'b10, 16'h1004, 64'd0, "R10");
    cyc(1, 0, 2'b00, 16'h1006, 64'd0, "R3");
    cyc(1, 1, 2'b10, 16'h1006, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    cyc(1, 0, 2'b10, 16'h1002, 64'd0, "R6");
    cyc(1, 1, 2'b11, 16'h1008, 64'hDEAD_BEEF_DEAD_BEEF, "R5");
    cyc(1, 0, 2'b11, 16'h1008, 64'd0, "R6");
    cyc(1, 1, 2'b11, 16'h1088, 64'h0102_0304_0506_0708, "R5");
    cyc(1, 0, 2'b11, 16'h1088, 64'd0, "R5");
    cyc(1, 0, 2'b10, 16'h108C, 64'd0, "R4");
    cyc(1, 0, 2'b00, 16'h1081, 64'd0, "R3");
    cyc(1, 0, 2'b11, 16'h1084, 64'd0, "R5");
    cyc(1, 0, 2'b01, 16'h1100, 64'd0, "R5");
    cyc(1, 1, 2'b01, 16'h1000, 64'hFFFF, "R7");
    cyc(1, 0, 2'b11, 16'h1100, 64'd0, "R8");
    cyc(1, 1, 2'b11, 16'h1100, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    cyc(1, 0, 2'b00, 16'h1107, 64'd0, "R8");
    cyc(1, 0, 2'b10, 16'h1204, 64'd0, "R8");
    cyc(1, 0, 2'b11, 16'h1200, 64'd0, "R8");
    cyc(1, 1, 2'b10, 16'h1200, 64'h1234_5678, "R8");
    cyc(1, 1, 2'b11, 16'h1300, 64'hCAFE_CAFE_CAFE_CAFE, "R9");
    cyc(1, 0, 2'b11, 16'h1300, 64'd0, "R9");
    cyc(1, 0, 2'b10, 16'h133C, 64'd0, "R9");
    cyc(1, 0, 2'b10, 16'h1090, 64'd0, "R2");
    cyc(1, 0, 2'b00, 16'h0FFF, 64'd0, "R1");
    cyc(1, 0, 2'b10, 16'h0FF8, 64'd0, "R1");
    cyc(1, 0, 2'b10, 16'h107C, 64'd0, "R2");
    cyc(1, 0, 2'b10, 16'h1080, 64'd0, "R2");
    cyc(1, 0, 2'b10, 16'h1340, 64'd0, "R2");
    cyc(1, 0, 2'b10, 16'h1010, 64'd0, "R11");
    cyc(1, 1, 2'b10, 16'h1010, 64'h0000_0000_9876_5432, "R11");
    cyc(1, 0, 2'b10, 16'h1010, 64'd0, "R11");
    cyc(0, 0, 2'b00, 16'h0000, 64'd0, "R11");
    for (int k = 0; k < 600; k++) begin
      logic [15:0] a;
      logic [1:0] sz;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = 16'h0FF0 + 16'(lcg[31:12] % 20'h360);
      sz = lcg[5:4];
      cyc(lcg[8], lcg[9], sz, a, {lcg, ~lcg}, "R2");
    end
    cyc(0, 0, 2'b00, 16'h0000, 64'd0, "R11");
    cyc(0, 0, 2'b00, 16'h0000, 64'd0, "R11");
    finish_run();
  end
endmodule